// File: doc/BRIEF.md
# JTAG TAP Command Sequencer

This block turns whole scan operations into a stream of TCK slots for a debug target whose TAP expects an extra fuse-check pattern after reset. A host hands it one of four commands on a valid/ready port. The commands are a reset to idle, a stand-alone fuse check, an instruction shift and a data shift. The block then emits one TMS/TDI pair per slot, along with a strobe that marks the slots in which TDO must be sampled. A separate physical layer consumes each slot with `slot_ready` and returns the target's TDO bit for that slot on `tdo_in`.

Every command leaves the TAP in Run-Test/Idle and expects it there at the start. The instruction and data paths use opposite bit orders. The instruction word goes out most significant bit first, and its capture is reversed back. The data word goes out least significant bit first, with no reversal. Shifting the all-ones instruction returns the captured instruction register, which the target presents as its 8-bit identifier. A data read is a data shift of an all-zero word.

Top module: `tap_cmd_seq`

## Requirements
- R1: Opcode 0 (reset) emits 14 slots with TMS 1,1,1,1,1,1,0,1,0,1,0,1,1,0 in that order. TDI is 1 in every slot and no slot carries the sample strobe.
- R2: Opcode 1 (fuse check) emits 8 slots with TMS 0,1,0,1,0,1,1,0 in that order. TDI is 1 in every slot and no slot carries the sample strobe.
- R3: Opcode 2 (instruction shift) emits 14 slots with TMS 1,1,0,0, then seven 0s, then 1, then 1,0.
- R4: Opcode 3 (data shift) emits 21 slots with TMS 1,0,0, then fifteen 0s, then 1, then 1,0.
- R5: In an instruction shift, the 8 shift slots carry cmd_data[7] first down to cmd_data[0] last on TDI. All other slots carry TDI=1.
- R6: In a data shift, the 16 shift slots carry cmd_data[0] first up to cmd_data[15] last on TDI. All other slots carry TDI=1.
- R7: The sample strobe is high in exactly the shift slots, including the final TMS=1 shift slot. The k-th sampled TDO bit (k from 0) goes to rsp_data[7-k] for an instruction shift, with rsp_data[15:8]=0. For a data shift it goes to rsp_data[k]. TDO is ignored in other slots.
- R8: cmd_ready stays low from the accepting edge until the final slot of the operation has been accepted. A cmd_valid seen while busy has no effect on the slot stream.
- R9: rsp_done pulses for one cycle in the cycle after the final slot is accepted. rsp_data then holds until the next rsp_done. For reset and fuse check, rsp_data is 0.
- R10: While slot_ready is low, the offered slot (TMS, TDI, strobe) stays unchanged.
- R11: After reset, cmd_ready is 1, and slot_valid, rsp_done and rsp_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken on valid |
| cmd_op | input | 2 | 0 reset, 1 fuse check, 2 instruction shift, 3 data shift |
| cmd_data | input | DR_W | Word to shift (low IR_W bits for instruction) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DR_W | Captured word |
| slot_valid | output | 1 | A TCK slot is offered |
| slot_ready | input | 1 | Physical layer consumes the slot |
| slot_tms | output | 1 | TMS value of the slot |
| slot_tdi | output | 1 | TDI value of the slot |
| slot_sample | output | 1 | TDO of this slot is captured |
| tdo_in | input | 1 | TDO returned for the offered slot |

## Verification
The hardest situation to reach is an operation that the physical layer stalls in the middle. The stall can land on a sample slot or on the final TMS=1 shift slot while the host keeps offering a different command. To get there, the stimulus drops slot_ready on every third slot cycle for a share of the operations. It also holds cmd_valid high with a changed opcode and word through the whole operation. The observed slot stream and captured word must then still match the original command exactly. Sweeping all 256 instruction values, and 256 spread data words with distinct TDO streams, covers both bit orders at every position.

// File: rtl/tap_seq_pkg.sv
package tap_seq_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_FUSE  = 2'd1,
        OP_IR    = 2'd2,
        OP_DR    = 2'd3
    } tap_op_e;

    // Slot k of each fixed pattern is bit k.
    localparam int          RST_LEN   = 14;
    localparam logic [13:0] RST_TMS   = 14'b01101010111111;
    localparam int          FUSE_LEN  = 8;
    localparam logic [7:0]  FUSE_TMS  = 8'b01101010;

    // Navigation from idle into the shift state.
    localparam int          IR_NAV    = 4;
    localparam logic [3:0]  IR_NAV_T  = 4'b0011;
    localparam int          DR_NAV    = 3;
    localparam logic [3:0]  DR_NAV_T  = 4'b0001;

    // Exit1 -> Update -> Idle tail.
    localparam int          POST_LEN  = 2;

endpackage

// File: rtl/tap_slot_decode.sv
module tap_slot_decode
    import tap_seq_pkg::*;
#(
    parameter int IR_W  = 8,
    parameter int DR_W  = 16,
    parameter int CNT_W = 5
) (
    input  tap_op_e          op,
    input  logic [CNT_W-1:0] cnt,
    output logic             tms,
    output logic             shift_slot,
    output logic             last_slot
);

    int       c;
    int       nav;
    int       wid;
    logic [3:0] nav_pat;

    always_comb begin
        c          = int'(cnt);
        tms        = 1'b0;
        shift_slot = 1'b0;
        last_slot  = 1'b0;
        nav        = (op == OP_IR) ? IR_NAV : DR_NAV;
        wid        = (op == OP_IR) ? IR_W : DR_W;
        nav_pat    = (op == OP_IR) ? IR_NAV_T : DR_NAV_T;
        case (op)
            OP_RESET: begin
                tms       = RST_TMS[cnt[3:0]];
                last_slot = (c == RST_LEN - 1);
            end
            OP_FUSE: begin
                tms       = FUSE_TMS[cnt[2:0]];
                last_slot = (c == FUSE_LEN - 1);
            end
            default: begin
                if (c < nav) begin
                    tms = nav_pat[cnt[1:0]];
                end else if (c < nav + wid) begin
                    shift_slot = 1'b1;
                    tms        = (c == nav + wid - 1);
                end else begin
                    tms       = (c == nav + wid);
                    last_slot = (c == nav + wid + POST_LEN - 1);
                end
            end
        endcase
    end

endmodule

// File: rtl/tap_shift_path.sv
module tap_shift_path #(
    parameter int DR_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DR_W-1:0] load_word,
    input  logic            step,
    input  logic            tdo,
    output logic            tdi_bit,
    output logic [DR_W-1:0] cap_word
);

    typedef struct packed {
        logic [DR_W-1:0] out;
        logic [DR_W-1:0] cap;
    } path_t;

    path_t path_d, path_q;

    always_comb begin
        path_d = path_q;
        if (load) begin
            path_d.out = load_word;
            path_d.cap = '0;
        end else if (step) begin
            path_d.out = {1'b0, path_q.out[DR_W-1:1]};
            path_d.cap = {tdo, path_q.cap[DR_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) path_q <= '0;
        else        path_q <= path_d;
    end

    assign tdi_bit  = path_q.out[0];
    assign cap_word = path_q.cap;

    // R7: a load never coincides with a capture step
    assert_load_step_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step)) else $error("load and step together");

endmodule

// File: rtl/tap_cmd_seq.sv
module tap_cmd_seq
    import tap_seq_pkg::*;
#(
    parameter int IR_W = 8,
    parameter int DR_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [1:0]      cmd_op,
    input  logic [DR_W-1:0] cmd_data,
    output logic            rsp_done,
    output logic [DR_W-1:0] rsp_data,
    output logic            slot_valid,
    input  logic            slot_ready,
    output logic            slot_tms,
    output logic            slot_tdi,
    output logic            slot_sample,
    input  logic            tdo_in
);

    localparam int IR_LEN  = IR_NAV + IR_W + POST_LEN;
    localparam int DR_LEN  = DR_NAV + DR_W + POST_LEN;
    localparam int MAX_A   = (IR_LEN > DR_LEN) ? IR_LEN : DR_LEN;
    localparam int MAX_LEN = (MAX_A > RST_LEN) ? MAX_A : RST_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic             busy;
        tap_op_e          op;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [DR_W-1:0]  rsp;
    } seq_t;

    seq_t seq_d, seq_q;

    logic            dec_tms, dec_shift, dec_last;
    logic            accept, slot_take;
    logic [DR_W-1:0] load_word, ir_word, cap_word, ir_result;
    logic            path_tdi;

    // Instruction bit reversal on the way out and on the way back.
    for (genvar j = 0; j < DR_W; j++) begin : g_rev
        if (j < IR_W) begin : g_ir
            assign ir_word[j]   = cmd_data[IR_W-1-j];
            assign ir_result[j] = cap_word[DR_W-1-j];
        end else begin : g_pad
            assign ir_word[j]   = 1'b0;
            assign ir_result[j] = 1'b0;
        end
    end

    tap_slot_decode #(
        .IR_W (IR_W),
        .DR_W (DR_W),
        .CNT_W(CNT_W)
    ) i_decode (
        .op        (seq_q.op),
        .cnt       (seq_q.cnt),
        .tms       (dec_tms),
        .shift_slot(dec_shift),
        .last_slot (dec_last)
    );

    assign accept    = cmd_valid && !seq_q.busy;
    assign slot_take = seq_q.busy && slot_ready;
    assign load_word = (tap_op_e'(cmd_op) == OP_IR) ? ir_word : cmd_data;

    tap_shift_path #(
        .DR_W(DR_W)
    ) i_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_word(load_word),
        .step     (slot_take && dec_shift),
        .tdo      (tdo_in),
        .tdi_bit  (path_tdi),
        .cap_word (cap_word)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (accept) begin
            seq_d.busy = 1'b1;
            seq_d.op   = tap_op_e'(cmd_op);
            seq_d.cnt  = '0;
        end else if (slot_take) begin
            if (dec_last) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
                case (seq_q.op)
                    OP_IR:   seq_d.rsp = ir_result;
                    OP_DR:   seq_d.rsp = cap_word;
                    default: seq_d.rsp = '0;
                endcase
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign cmd_ready   = !seq_q.busy;
    assign slot_valid  = seq_q.busy;
    assign slot_tms    = dec_tms;
    assign slot_sample = seq_q.busy && dec_shift;
    assign slot_tdi    = dec_shift ? path_tdi : 1'b1;
    assign rsp_done    = seq_q.done;
    assign rsp_data    = seq_q.rsp;

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done) else $error("done longer than one cycle");

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid && !slot_ready |=> slot_valid && $stable(slot_tms)
            && $stable(slot_tdi) && $stable(slot_sample))
        else $error("slot changed during stall");

    assert_last_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid && slot_ready && dec_last |=> rsp_done && cmd_ready)
        else $error("final slot did not complete the command");

    assert_sample_shift_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_sample |-> (seq_q.op == OP_IR || seq_q.op == OP_DR))
        else $error("sample strobe outside a register shift");

    assert_tdi_high_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid && (seq_q.op == OP_RESET || seq_q.op == OP_FUSE) |-> slot_tdi)
        else $error("TDI low in a fixed pattern");

endmodule

// File: tb/test_tap_cmd_seq.sv
module test_tap_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_data = 16'd0;
    logic        rsp_done;
    logic [15:0] rsp_data;
    logic        slot_valid;
    logic        slot_ready = 1'b0;
    logic        slot_tms, slot_tdi, slot_sample;
    logic        tdo_in = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    tap_cmd_seq #(.IR_W(8), .DR_W(16)) i_tap_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_done(rsp_done),
        .rsp_data(rsp_data), .slot_valid(slot_valid), .slot_ready(slot_ready),
        .slot_tms(slot_tms), .slot_tdi(slot_tdi), .slot_sample(slot_sample),
        .tdo_in(tdo_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog expired act=%0d exp<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int e_len(input logic [1:0] op);
        case (op)
            2'd0: return 14;
            2'd1: return 8;
            2'd2: return 14;
            default: return 21;
        endcase
    endfunction

    function automatic logic [31:0] e_tms(input logic [1:0] op);
        case (op)
            2'd0: return 32'h0000_1ABF;
            2'd1: return 32'h0000_006A;
            2'd2: return 32'h0000_1803;
            default: return 32'h000C_0001;
        endcase
    endfunction

    function automatic logic [31:0] e_samp(input logic [1:0] op);
        case (op)
            2'd2: return 32'h0000_0FF0;
            2'd3: return 32'h0007_FFF8;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] e_tdi(input logic [1:0] op, input logic [15:0] d);
        logic [31:0] t = '0;
        for (int k = 0; k < e_len(op); k++) t[k] = 1'b1;
        if (op == 2'd2) for (int k = 0; k < 8; k++) t[4+k] = d[7-k];
        if (op == 2'd3) for (int k = 0; k < 16; k++) t[3+k] = d[k];
        return t;
    endfunction

    function automatic logic [15:0] e_rsp(input logic [1:0] op, input logic [15:0] t);
        logic [15:0] r = '0;
        if (op == 2'd2) for (int k = 0; k < 8; k++) r[7-k] = t[k];
        if (op == 2'd3) r = t;
        return r;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [15:0] data,
                          input logic [15:0] tdo_bits, input bit stall, input bit pester);
        logic [31:0] o_tms = '0, o_tdi = '0, o_smp = '0;
        int n = 0, s = 0, cyc = 0, busy_ready = 0;
        logic [15:0] held;
        @(negedge clk);
        chk("R8 ready before command", {31'd0, cmd_ready}, 32'd1);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
        @(negedge clk);
        if (pester) begin
            cmd_op = op + 2'd1; cmd_data = ~data;
        end else begin
            cmd_valid = 1'b0;
        end
        while (slot_valid) begin
            if (cmd_ready) busy_ready++;
            slot_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            tdo_in = (slot_sample && s < 16) ? tdo_bits[s] : 1'b0;
            if (slot_ready) begin
                o_tms[n] = slot_tms; o_tdi[n] = slot_tdi; o_smp[n] = slot_sample;
                if (slot_sample) s++;
                n++;
            end
            cyc++;
            @(negedge clk);
        end
        cmd_valid = 1'b0; slot_ready = 1'b0; tdo_in = 1'b0;
        chk("R1 R2 R3 R4 slot count", n, e_len(op));
        chk("R1 R2 R3 R4 TMS stream", o_tms, e_tms(op));
        chk("R5 R6 TDI stream", o_tdi, e_tdi(op, data));
        chk("R7 sample strobes", o_smp, e_samp(op));
        chk("R8 ready low while busy", busy_ready, 0);
        chk("R9 done after last slot", {31'd0, rsp_done}, 32'd1);
        chk("R8 ready at done", {31'd0, cmd_ready}, 32'd1);
        chk("R7 R9 captured word", {16'd0, rsp_data}, {16'd0, e_rsp(op, tdo_bits)});
        held = rsp_data;
        @(negedge clk);
        chk("R9 done is one cycle", {31'd0, rsp_done}, 32'd0);
        chk("R9 result held", {16'd0, rsp_data}, {16'd0, held});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset ready", {31'd0, cmd_ready}, 32'd1);
        chk("R11 reset slot_valid", {31'd0, slot_valid}, 32'd0);
        chk("R11 reset done", {31'd0, rsp_done}, 32'd0);
        chk("R11 reset data", {16'd0, rsp_data}, 32'd0);
        rst_n = 1'b1;

        // R1 and R2 with and without stalls and a pestering host (R8, R10)
        run_op(2'd0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
        run_op(2'd1, 16'h0000, 16'hFFFF, 1'b0, 1'b0);
        run_op(2'd0, 16'h1234, 16'hAAAA, 1'b1, 1'b1);
        run_op(2'd1, 16'h5678, 16'h5555, 1'b1, 1'b1);

        // R3 R5 R7: every instruction value
        for (int v = 0; v < 256; v++)
            run_op(2'd2, 16'(v), 16'((v * 37 + 5) & 8'hFF), (v % 4) == 0, (v % 5) == 0);

        // R4 R6 R7: spread data words, distinct TDO streams
        for (int v = 0; v < 256; v++)
            run_op(2'd3, 16'((v * 257) ^ (v << 3)), 16'((v * 40503 + 12345) & 16'hFFFF),
                   (v % 3) == 0, (v % 7) == 0);

        // R7: all-ones instruction returns the identifier; data read of zero word
        run_op(2'd2, 16'h00FF, 16'h0091, 1'b0, 1'b0);
        chk("R7 identifier", {16'd0, rsp_data}, 32'h0000_0089);
        run_op(2'd3, 16'h0000, 16'hC3A5, 1'b1, 1'b0);
        chk("R7 data read", {16'd0, rsp_data}, 32'h0000_C3A5);
        // R9: reset after a shift clears the result
        run_op(2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule